// File: doc/BRIEF.md
# Incremental PI Step Engine

This block computes one step of a discrete proportional-integral controller written in velocity form. It sits in a sampled feedback loop between an ADC and a DAC. The caller presents a signed setpoint, a signed measured sample, two signed fixed-point gains (21 integer bits, 43 fraction bits), the error from the previous step and the previous unsaturated adjustment. The caller then raises `arm`. The block captures these operands. It forms the new error and multiplies each gain by its error in two Booth sequential multipliers that run in parallel. From the two products and the previous adjustment it builds the next adjustment.

The full-precision adjustment is returned so that it can be fed back on the next step, together with the current error. A reduced copy is also returned, sized for the DAC. To make it, low fraction bits are dropped so that `DAC_W - ADC_W` fraction bits remain. The value is then clamped to a signed `DAC_W`-bit field and read as a plain integer increment for the stored DAC code. `finished` rises once both multipliers are done. It stays high while `arm` is held, and dropping `arm` makes the block ready for the next step.

Top module: `pi_step_unit`

## Requirements
- R1: After reset, `finished` is low and stays low until a step has been armed and completed.
- R2: `err_cur` equals `meas - setpt`, computed as a signed value of `ADC_W+1` bits from the operands sampled on the capture edge.
- R3: `adj_next` equals `adj_prev + gain_i*err_cur - gain_p*err_prev`. The gains are signed with `GAIN_FRAC` fraction bits, the products are exact, and the sum wraps in two's complement at `ADJ_W = GAIN_INT+GAIN_FRAC+ADC_W+2` bits.
- R4: `dac_step` is `adj_next` shifted right arithmetically by `GAIN_FRAC-(DAC_W-ADC_W)` bits. When the result fits a signed `DAC_W`-bit field it is passed through unchanged.
- R5: When the shifted value exceeds the signed `DAC_W`-bit range, `dac_step` is clamped to `2^(DAC_W-1)-1` (positive) or `-2^(DAC_W-1)` (negative).
- R6: Arm is sampled on rising clock edges. The capture edge is the first edge that samples `arm` high while the block is idle. Counting the capture edge as edge 1, `finished` goes high after edge `ADC_W+4`. That is the first edge after both multipliers report done.
- R7: `finished` stays high while `arm` stays high. It goes low after the first edge that samples `arm` low, and the block is then idle.
- R8: Operand inputs are sampled only on the capture edge. Changing them at any later point before the next capture has no effect on `err_cur`, `adj_next` or `dac_step`.
- R9: If `arm` falls before `finished` rises, the step still completes. `finished` is then high for exactly one cycle, with valid results.
- R10: Results are exact for full-range operands, including the most negative gain and the extreme ADC codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| arm | input | 1 | Start request, level sensitive |
| setpt | input | ADC_W | Signed setpoint |
| meas | input | ADC_W | Signed measured sample |
| gain_p | input | GAIN_INT+GAIN_FRAC | Signed P gain, fixed point |
| gain_i | input | GAIN_INT+GAIN_FRAC | Signed I gain, fixed point |
| err_prev | input | ADC_W+1 | Error of the previous step |
| adj_prev | input | ADJ_W | Unsaturated adjustment of the previous step |
| finished | output | 1 | Results valid |
| err_cur | output | ADC_W+1 | Current error |
| adj_next | output | ADJ_W | New unsaturated adjustment |
| dac_step | output | DAC_W | Trimmed and clamped adjustment for the DAC |

## Verification
Two events can land in the same cycle: the release of `arm` and the arrival of both multiplier done flags. They also coincide when `arm` is pulled early, in the middle of a computation. The bench releases `arm` at several points: before completion, exactly around completion, and long after it. The behavioural model then decides, edge by edge, whether `finished` must show a single-cycle pulse or a held level. A second overlap is between the capture edge and operand changes. The bench changes every operand while a step is still running. The model holds the values from the capture edge, so any late sampling shows up as a miscompare on the results.

// File: rtl/pi_step_pkg.sv
package pi_step_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LAUNCH = 2'd1,
    ST_BUSY   = 2'd2,
    ST_DONE   = 2'd3
  } pi_state_e;
endpackage

// File: rtl/pi_booth_mul.sv
module pi_booth_mul #(
  parameter int MC_W = 64,
  parameter int MP_W = 19
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [MC_W-1:0]        mcand,
  input  logic [MP_W-1:0]        mplier,
  output logic [MC_W+MP_W-1:0]   product,
  output logic                   done
);
  localparam int ACC_W = MC_W + 1;
  localparam int CNT_W = $clog2(MP_W + 1);
  localparam int CAT_W = ACC_W + MP_W + 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MP_W - 1);

  logic [ACC_W-1:0] acc_q, acc_n;
  logic [MP_W-1:0]  mq_q, mq_n;
  logic             q1_q, q1_n;
  logic [MC_W-1:0]  mc_q, mc_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             run_q, run_n;
  logic             done_q, done_n;

  logic [ACC_W-1:0] mc_ext;
  logic [ACC_W-1:0] acc_sum;
  logic [CAT_W-1:0] cat_sh;

  assign mc_ext = {mc_q[MC_W-1], mc_q};

  // Booth recoding of the current multiplier bit pair
  always_comb begin
    unique case ({mq_q[0], q1_q})
      2'b01:   acc_sum = acc_q + mc_ext;
      2'b10:   acc_sum = acc_q - mc_ext;
      default: acc_sum = acc_q;
    endcase
    cat_sh = CAT_W'($signed({acc_sum, mq_q, q1_q}) >>> 1);
  end

  always_comb begin
    acc_n  = acc_q;
    mq_n   = mq_q;
    q1_n   = q1_q;
    mc_n   = mc_q;
    cnt_n  = cnt_q;
    run_n  = run_q;
    done_n = done_q;
    if (start) begin
      acc_n  = '0;
      mq_n   = mplier;
      q1_n   = 1'b0;
      mc_n   = mcand;
      cnt_n  = '0;
      run_n  = 1'b1;
      done_n = 1'b0;
    end else if (run_q) begin
      {acc_n, mq_n, q1_n} = cat_sh;
      cnt_n = cnt_q + 1'b1;
      if (cnt_q == LAST) begin
        run_n  = 1'b0;
        done_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      mq_q   <= '0;
      q1_q   <= 1'b0;
      mc_q   <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      acc_q  <= acc_n;
      mq_q   <= mq_n;
      q1_q   <= q1_n;
      mc_q   <= mc_n;
      cnt_q  <= cnt_n;
      run_q  <= run_n;
      done_q <= done_n;
    end
  end

  assign product = {acc_q[MC_W-1:0], mq_q};
  assign done    = done_q;

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);                                 // R6
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done);                                           // R6
endmodule

// File: rtl/pi_trim_sat.sv
module pi_trim_sat #(
  parameter int IN_W  = 84,
  parameter int DROP  = 41,
  parameter int OUT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IN_W-1:0]  din,
  output logic [OUT_W-1:0] dout
);
  localparam int TW = IN_W - DROP;
  localparam logic [OUT_W-1:0] POS_MAX = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] NEG_MIN = {1'b1, {(OUT_W-1){1'b0}}};

  logic [TW-1:0] trimmed;
  assign trimmed = din[IN_W-1:DROP];

  generate
    if (TW > OUT_W) begin : g_clamp
      logic [TW-OUT_W:0] top_bits;
      logic              ovf;
      assign top_bits = trimmed[TW-1:OUT_W-1];
      assign ovf      = !((&top_bits) || !(|top_bits));
      assign dout     = ovf ? (trimmed[TW-1] ? NEG_MIN : POS_MAX)
                            : trimmed[OUT_W-1:0];

      AST_CLAMP_EXTREME: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> (dout == POS_MAX || dout == NEG_MIN));          // R5
      AST_CLAMP_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> (dout[OUT_W-1] == din[IN_W-1]));                // R5
    end else begin : g_extend
      assign dout = OUT_W'($signed(trimmed));
    end
  endgenerate
endmodule

// File: rtl/pi_step_unit.sv
module pi_step_unit
  import pi_step_pkg::*;
#(
  parameter int ADC_W     = 18,
  parameter int DAC_W     = 20,
  parameter int GAIN_INT  = 21,
  parameter int GAIN_FRAC = 43,
  localparam int GAIN_W   = GAIN_INT + GAIN_FRAC,
  localparam int ERR_W    = ADC_W + 1,
  localparam int PROD_W   = GAIN_W + ERR_W,
  localparam int ADJ_W    = PROD_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic [ADC_W-1:0]  setpt,
  input  logic [ADC_W-1:0]  meas,
  input  logic [GAIN_W-1:0] gain_p,
  input  logic [GAIN_W-1:0] gain_i,
  input  logic [ERR_W-1:0]  err_prev,
  input  logic [ADJ_W-1:0]  adj_prev,
  output logic              finished,
  output logic [ERR_W-1:0]  err_cur,
  output logic [ADJ_W-1:0]  adj_next,
  output logic [DAC_W-1:0]  dac_step
);
  localparam int KEEP_FRAC = DAC_W - ADC_W;
  localparam int DROP      = GAIN_FRAC - KEEP_FRAC;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  pi_state_e st_q, st_n;
  logic cap_en;
  logic [GAIN_W-1:0] gp_q, gi_q;
  logic [ERR_W-1:0]  ep_q, err_q, err_calc;
  logic [ADJ_W-1:0]  ap_q;
  logic [PROD_W-1:0] prod_i, prod_p;
  logic done_i, done_p, both_done, mul_go;

  assign cap_en    = (st_q == ST_IDLE) && arm;
  assign mul_go    = (st_q == ST_LAUNCH);
  assign both_done = done_i & done_p;
  assign err_calc  = {meas[ADC_W-1], meas} - {setpt[ADC_W-1], setpt};

  always_comb begin
    st_n = st_q;
    unique case (st_q)
      ST_IDLE:   if (arm) st_n = ST_LAUNCH;
      ST_LAUNCH: st_n = ST_BUSY;
      ST_BUSY:   if (both_done) st_n = ST_DONE;
      ST_DONE:   if (!arm) st_n = ST_IDLE;
      default:   st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_n;
  end

  // operand capture, enabled only on the capture edge
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      gp_q  <= '0;
      gi_q  <= '0;
      ep_q  <= '0;
      ap_q  <= '0;
      err_q <= '0;
    end else if (cap_en) begin
      gp_q  <= gain_p;
      gi_q  <= gain_i;
      ep_q  <= err_prev;
      ap_q  <= adj_prev;
      err_q <= err_calc;
    end
  end

  pi_booth_mul #(.MC_W(GAIN_W), .MP_W(ERR_W)) u_mul_i (
    .clk(clk), .rst_n(rst_ni), .start(mul_go),
    .mcand(gi_q), .mplier(err_q), .product(prod_i), .done(done_i)
  );

  pi_booth_mul #(.MC_W(GAIN_W), .MP_W(ERR_W)) u_mul_p (
    .clk(clk), .rst_n(rst_ni), .start(mul_go),
    .mcand(gp_q), .mplier(ep_q), .product(prod_p), .done(done_p)
  );

  assign adj_next = ap_q + {prod_i[PROD_W-1], prod_i} - {prod_p[PROD_W-1], prod_p};

  pi_trim_sat #(.IN_W(ADJ_W), .DROP(DROP), .OUT_W(DAC_W)) u_trim (
    .clk(clk), .rst_n(rst_ni), .din(adj_next), .dout(dac_step)
  );

  assign finished = (st_q == ST_DONE);
  assign err_cur  = err_q;

  AST_FIN_BOTH_DONE: assert property (@(posedge clk) disable iff (!rst_ni)
    finished |-> (done_i && done_p));                           // R6
  AST_FIN_HELD: assert property (@(posedge clk) disable iff (!rst_ni)
    (finished && arm) |=> finished);                            // R7
  AST_FIN_RELEASE: assert property (@(posedge clk) disable iff (!rst_ni)
    (finished && !arm) |=> !finished);                          // R7
  AST_OPERANDS_FROZEN: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_q != ST_IDLE) |=> ($stable(err_q) && $stable(ap_q)));   // R8
endmodule

// File: tb/pi_step_unit_tb.sv
module pi_step_unit_tb;
  localparam int ADC_W = 18, DAC_W = 20, GAIN_INT = 21, GAIN_FRAC = 43;
  localparam int GAIN_W = GAIN_INT + GAIN_FRAC;
  localparam int ERR_W  = ADC_W + 1;
  localparam int ADJ_W  = GAIN_W + ERR_W + 1;
  localparam int DROP   = GAIN_FRAC - (DAC_W - ADC_W);
  localparam int LAT    = ERR_W + 2;

  logic clk = 1'b0, rst_n = 1'b0, arm = 1'b0;
  logic [ADC_W-1:0]  setpt = '0, meas = '0;
  logic [GAIN_W-1:0] gain_p = '0, gain_i = '0;
  logic [ERR_W-1:0]  err_prev = '0;
  logic [ADJ_W-1:0]  adj_prev = '0;
  logic finished;
  logic [ERR_W-1:0]  err_cur;
  logic [ADJ_W-1:0]  adj_next;
  logic [DAC_W-1:0]  dac_step;

  int vectors = 0, miscompares = 0;
  string tag = "R1";

  pi_step_unit u_dut (
    .clk(clk), .rst_n(rst_n), .arm(arm), .setpt(setpt), .meas(meas),
    .gain_p(gain_p), .gain_i(gain_i), .err_prev(err_prev), .adj_prev(adj_prev),
    .finished(finished), .err_cur(err_cur), .adj_next(adj_next), .dac_step(dac_step)
  );

  always #4 clk = ~clk;

  // behavioural reference model
  int m_mode = 0;   // 0 idle, 1 computing, 2 done
  int m_cnt  = 0;
  logic x_fin = 1'b0;
  logic signed [ERR_W-1:0] x_err;
  logic signed [ADJ_W-1:0] x_adj;
  logic signed [DAC_W-1:0] x_dac;

  task automatic predict();
    logic signed [ERR_W-1:0] e;
    logic signed [ADJ_W-1:0] pi, pp, t, hi, lo;
    e  = $signed(meas) - $signed(setpt);
    pi = $signed(gain_i) * $signed(e);
    pp = $signed(gain_p) * $signed(err_prev);
    x_err = e;
    x_adj = $signed(adj_prev) + pi - pp;
    t  = x_adj >>> DROP;
    hi = {{(ADJ_W-DAC_W+1){1'b0}}, {(DAC_W-1){1'b1}}};
    lo = ~hi;
    if (t > hi)      x_dac = hi[DAC_W-1:0];
    else if (t < lo) x_dac = lo[DAC_W-1:0];
    else             x_dac = t[DAC_W-1:0];
  endtask

  logic rst_seen = 1'b0;
  int   rst_edges = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; x_fin = 1'b0; rst_edges = 0;
    end else if (rst_edges < 2) begin
      rst_edges++;       // internal reset release takes two edges
    end else begin
      case (m_mode)
        0: if (arm) begin predict(); m_mode = 1; m_cnt = 0; end
        1: begin m_cnt++; if (m_cnt == LAT) begin m_mode = 2; x_fin = 1'b1; end end
        default: if (!arm) begin m_mode = 0; x_fin = 1'b0; end
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      vectors++;
      if (finished !== x_fin) begin
        miscompares++;
        $display("FAIL R6 R7 %s finished: actual %0b expected %0b", tag, finished, x_fin);
      end
      if (x_fin) begin
        vectors++;
        if (err_cur !== x_err) begin
          miscompares++;
          $display("FAIL R2 %s err_cur: actual %0d expected %0d", tag, $signed(err_cur), x_err);
        end
        if (adj_next !== x_adj) begin
          miscompares++;
          $display("FAIL R3 %s adj_next: actual %h expected %h", tag, adj_next, x_adj);
        end
        if (dac_step !== x_dac) begin
          miscompares++;
          $display("FAIL R4 %s dac_step: actual %0d expected %0d", tag, $signed(dac_step), x_dac);
        end
      end
    end
  end

  task automatic drive(input logic [ADC_W-1:0] s, input logic [ADC_W-1:0] m,
                       input logic [GAIN_W-1:0] gp, input logic [GAIN_W-1:0] gi,
                       input logic [ERR_W-1:0] ep, input logic [ADJ_W-1:0] ap);
    setpt = s; meas = m; gain_p = gp; gain_i = gi; err_prev = ep; adj_prev = ap;
  endtask

  task automatic step(input int hold, input logic scramble);
    @(posedge clk); #2; arm = 1'b1;
    if (scramble) begin
      repeat (2) @(posedge clk); #2;
      drive(ADC_W'($urandom), ADC_W'($urandom), {$urandom, $urandom},
            {$urandom, $urandom}, ERR_W'($urandom), {$urandom, $urandom, $urandom});
      repeat (hold - 2) @(posedge clk);
    end else begin
      repeat (hold) @(posedge clk);
    end
    #2; arm = 1'b0;
    repeat (LAT + 3) @(posedge clk);
  endtask

  localparam logic [GAIN_W-1:0] ONE = GAIN_W'(1) << GAIN_FRAC;

  initial begin
    repeat (3) @(posedge clk);
    #2; rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2;
    tag = "R1";
    vectors++;
    if (finished !== 1'b0) begin
      miscompares++;
      $display("FAIL R1 finished after reset: actual %0b expected 0", finished);
    end
    // zero gains: adjustment passes through
    tag = "R3";
    drive(18'd100, 18'd40, '0, '0, 19'd5, ADJ_W'(123) << DROP);
    step(LAT + 4, 1'b0);
    // unit gains, small values
    tag = "R4";
    drive(18'd1000, 18'd1010, ONE, ONE, 19'd3, '0);
    step(LAT + 4, 1'b0);
    // positive clamp
    tag = "R5";
    drive(18'h20000, 18'h1FFFF, '0, {1'b0, {(GAIN_W-1){1'b1}}}, '0, '0);
    step(LAT + 4, 1'b0);
    // negative clamp
    tag = "R5";
    drive(18'h1FFFF, 18'h20000, '0, {1'b0, {(GAIN_W-1){1'b1}}}, '0, '0);
    step(LAT + 4, 1'b0);
    // most negative gain against extreme errors
    tag = "R10";
    drive(18'h1FFFF, 18'h20000, {1'b1, {(GAIN_W-1){1'b0}}},
          {1'b1, {(GAIN_W-1){1'b0}}}, {1'b1, {(ERR_W-1){1'b0}}}, '0);
    step(LAT + 4, 1'b0);
    // operands changed while computing
    tag = "R8";
    drive(18'd7, 18'd3, ONE >> 3, ONE << 2, 19'h7FFF0, ADJ_W'(55) << GAIN_FRAC);
    step(LAT + 4, 1'b1);
    // arm released early: single-cycle finished
    tag = "R9";
    drive(18'd9, 18'd500, ONE, ONE >> 1, 19'd12, '0);
    step(5, 1'b0);
    // arm released right around completion
    for (int k = LAT - 1; k <= LAT + 2; k++) begin
      tag = "R9";
      drive(ADC_W'($urandom), ADC_W'($urandom), ONE >> (k % 4), ONE, ERR_W'($urandom), '0);
      step(k, 1'b0);
    end
    // long hold then back-to-back re-arm
    tag = "R7";
    drive(18'd4, 18'd2, ONE, ONE, 19'd1, '0);
    step(LAT + 20, 1'b0);
    // random operands with moderate gains
    for (int n = 0; n < 40; n++) begin
      logic [GAIN_W-1:0] rp, ri;
      tag = "R3";
      rp = {$urandom, $urandom};
      ri = {$urandom, $urandom};
      drive(ADC_W'($urandom), ADC_W'($urandom),
            GAIN_W'($signed(rp) >>> (n % 24)), GAIN_W'($signed(ri) >>> (n % 24)),
            ERR_W'($urandom), ADJ_W'($signed({$urandom, $urandom}) <<< 20));
      step(LAT + 1 + (n % 5), n[0]);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(8 * 150000);
    miscompares++;
    $display("FAIL watchdog: run did not end, actual running expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule